// File: doc/BRIEF.md
# Linked-List Summing Engine

This block adds up the signed 8-bit values held in a singly linked chain of nodes that sits in a single-ported memory with combinational read. Each node takes two consecutive byte locations. The lower location holds the address of the following node, and the location one above holds the node's value. The chain always begins at address 0 and always has at least one node. A link of 0 ends the chain.

A one-cycle `start` pulse clears the running total, points the engine at the head node and starts the walk. Each node takes exactly two cycles, because the memory allows only one access per cycle. In the first cycle the engine reads the value and accumulates it. In the second it reads the link, and in that same cycle it works out where the following node's value lives, so that the first cycle of every node starts with its value address already held in a register. When a link of 0 is read, the final total appears on `result` and `done` goes high. Both stay put until the next `start`.

A parameter chooses between two datapaths. One uses a separate adder for the running total and for the address increment. The other uses a single adder whose inputs are switched between the two cycles. Both behave identically at the ports.

Top module: `list_sum_engine`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0, and no traversal is in progress.
- R2: A `start` sampled high while no traversal is running begins a new one. In the following cycle `mem_addr` is 1 (the head node's value address) and `done` is 0.
- R3: Each node costs two cycles. In the value cycle `mem_addr` is the node's address plus one, and the byte read there is sign-extended to 16 bits and added to the running total. In the link cycle that directly follows, `mem_addr` is the node's own address.
- R4: The byte read in a link cycle becomes the next node's address. Its value address is that byte plus one, taken modulo 256, so a node at address 255 keeps its value at address 0.
- R5: A link byte of 0 ends the walk. For a chain of N nodes, `done` is high and `result` holds the 16-bit two's-complement sum of the N values after the 2N-th rising edge following the edge that captured `start`.
- R6: Once high, `done` and `result` hold their values until the next `start` is captured.
- R7: A `start` pulse that arrives while a traversal is running is ignored. The running walk, its final `result` and its cycle count are unchanged.
- R8: With `SHARED_ADDER` set to 1, the single shared adder gives the same port behaviour, cycle for cycle, as the two-adder datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a traversal from the head node |
| mem_addr | output | 8 | Address presented to the list memory |
| mem_rdata | input | 8 | Combinational read data for `mem_addr` |
| done | output | 1 | High once the walk has ended, until the next start |
| result | output | 16 | Final signed sum of the node values |

## Verification
The bench builds two copies of the engine side by side on one shared memory image. Both use the default 8-bit data and 16-bit sum widths; one sets `SHARED_ADDER` to 0 and the other to 1. Every chain therefore drives both the split-adder datapath and the time-shared one, and their results and timing can be compared directly. The default widths let the bench reach the cases that matter: the most negative and most positive bytes, a value address that wraps past 255 to 0, and a 100-node chain whose total runs far beyond the 8-bit range.

// File: rtl/lsum_pkg.sv
package lsum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VALUE  = 2'd1,
        ST_LINK   = 2'd2,
        ST_FINISH = 2'd3
    } lsum_state_e;

    typedef enum logic {
        ADDR_FROM_VAL  = 1'b0,
        ADDR_FROM_LINK = 1'b1
    } addr_src_e;

endpackage

// File: rtl/lsum_ctrl.sv
module lsum_ctrl
    import lsum_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      link_is_end,
    output logic      ld_init,
    output logic      ld_sum,
    output logic      ld_link,
    output logic      ld_result,
    output addr_src_e addr_src,
    output logic      done,
    output logic      busy,
    output logic      link_phase
);

    typedef struct packed {
        lsum_state_e state;
    } ctrl_regs_t;

    ctrl_regs_t r_q;
    ctrl_regs_t r_d;

    always_comb begin
        r_d       = r_q;
        ld_init   = 1'b0;
        ld_sum    = 1'b0;
        ld_link   = 1'b0;
        ld_result = 1'b0;
        addr_src  = ADDR_FROM_LINK;
        unique case (r_q.state)
            ST_IDLE, ST_FINISH: begin
                if (start) begin
                    ld_init     = 1'b1;
                    r_d.state   = ST_VALUE;
                end
            end
            ST_VALUE: begin
                addr_src  = ADDR_FROM_VAL;
                ld_sum    = 1'b1;
                r_d.state = ST_LINK;
            end
            ST_LINK: begin
                addr_src = ADDR_FROM_LINK;
                ld_link  = 1'b1;
                if (link_is_end) begin
                    ld_result = 1'b1;
                    r_d.state = ST_FINISH;
                end else begin
                    r_d.state = ST_VALUE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done       = (r_q.state == ST_FINISH);
    assign busy       = (r_q.state == ST_VALUE) || (r_q.state == ST_LINK);
    assign link_phase = (r_q.state == ST_LINK);

endmodule

// File: rtl/lsum_datapath.sv
module lsum_datapath
    import lsum_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SUM_W        = 16,
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_init,
    input  logic              ld_sum,
    input  logic              ld_link,
    input  logic              ld_result,
    input  addr_src_e         addr_src,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic              link_is_end,
    output logic [SUM_W-1:0]  result
);

    localparam int ADDR_W    = DATA_W;
    localparam int EXT_W     = SUM_W - DATA_W;
    localparam logic [ADDR_W-1:0] HEAD_ADDR = '0;
    localparam logic [ADDR_W-1:0] HEAD_VAL  = HEAD_ADDR + ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] link;
        logic [ADDR_W-1:0] val_addr;
        logic [SUM_W-1:0]  acc;
        logic [SUM_W-1:0]  result;
    } dp_regs_t;

    dp_regs_t r_q;
    dp_regs_t r_d;

    logic [SUM_W-1:0]  value_ext;
    logic [SUM_W-1:0]  acc_sum;
    logic [ADDR_W-1:0] addr_inc;

    assign value_ext = {{EXT_W{mem_rdata[DATA_W-1]}}, mem_rdata};

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [SUM_W-1:0] op_a;
            logic [SUM_W-1:0] op_b;
            logic [SUM_W-1:0] add_o;
            always_comb begin
                if (addr_src == ADDR_FROM_LINK) begin
                    op_a = {{EXT_W{1'b0}}, mem_rdata};
                    op_b = SUM_W'(1);
                end else begin
                    op_a = r_q.acc;
                    op_b = value_ext;
                end
            end
            assign add_o    = op_a + op_b;
            assign acc_sum  = add_o;
            assign addr_inc = add_o[ADDR_W-1:0];
        end else begin : g_split
            assign acc_sum  = r_q.acc + value_ext;
            assign addr_inc = mem_rdata + ADDR_W'(1);
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (ld_init) begin
            r_d.link     = HEAD_ADDR;
            r_d.val_addr = HEAD_VAL;
            r_d.acc      = '0;
        end
        if (ld_sum) begin
            r_d.acc = acc_sum;
        end
        if (ld_link) begin
            r_d.link     = mem_rdata;
            r_d.val_addr = addr_inc;
        end
        if (ld_result) begin
            r_d.result = r_q.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.link     <= HEAD_ADDR;
            r_q.val_addr <= HEAD_VAL;
            r_q.acc      <= '0;
            r_q.result   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr    = (addr_src == ADDR_FROM_VAL) ? r_q.val_addr : r_q.link;
    assign link_is_end = (mem_rdata == '0);
    assign result      = r_q.result;

endmodule

// File: rtl/list_sum_engine.sv
module list_sum_engine
    import lsum_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SUM_W        = 16,
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [SUM_W-1:0]  result
);

    logic      ld_init;
    logic      ld_sum;
    logic      ld_link;
    logic      ld_result;
    logic      link_is_end;
    logic      busy;
    logic      link_phase;
    addr_src_e addr_src;

    lsum_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .link_is_end(link_is_end),
        .ld_init    (ld_init),
        .ld_sum     (ld_sum),
        .ld_link    (ld_link),
        .ld_result  (ld_result),
        .addr_src   (addr_src),
        .done       (done),
        .busy       (busy),
        .link_phase (link_phase)
    );

    lsum_datapath #(
        .DATA_W      (DATA_W),
        .SUM_W       (SUM_W),
        .SHARED_ADDER(SHARED_ADDER)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_init    (ld_init),
        .ld_sum     (ld_sum),
        .ld_link    (ld_link),
        .ld_result  (ld_result),
        .addr_src   (addr_src),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .link_is_end(link_is_end),
        .result     (result)
    );

endmodule

// File: rtl/lsum_checker.sv
module lsum_checker #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              done,
    input logic [SUM_W-1:0]  result,
    input logic              busy,
    input logic              link_phase
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !done && !busy && result == '0); // R1

    AST_START_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy && !done && !link_phase && mem_addr == DATA_W'(1)); // R2

    AST_VALUE_THEN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !link_phase) |=> busy && link_phase); // R3

    AST_NEXT_VALUE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase && mem_rdata != '0) |=> !link_phase && busy && mem_addr == DATA_W'($past(mem_rdata) + DATA_W'(1))); // R4

    AST_END_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase && mem_rdata == '0) |=> done && !busy); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(result)); // R6

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !link_phase && start) |=> busy && link_phase); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R5

endmodule

bind list_sum_engine lsum_checker #(
    .DATA_W(DATA_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .done      (done),
    .result    (result),
    .busy      (busy),
    .link_phase(link_phase)
);

// File: tb/tb_list_sum_engine.sv
`timescale 1ns/1ps
module tb_list_sum_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  addr_a, addr_b;
    logic [7:0]  rd_a, rd_b;
    logic        done_a, done_b;
    logic [15:0] res_a, res_b;

    logic [7:0]  mem [256];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int launch_cyc = 0;
    bit prev_done = 1'b0;
    bit finished = 1'b0;

    logic [15:0] exp_sum_q [$];
    int          exp_lat_q [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rd_a = mem[addr_a];
    assign rd_b = mem[addr_b];

    list_sum_engine #(.DATA_W(8), .SUM_W(16), .SHARED_ADDER(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_a),
        .mem_rdata(rd_a), .done(done_a), .result(res_a)
    );

    list_sum_engine #(.DATA_W(8), .SUM_W(16), .SHARED_ADDER(1'b1)) dut_sh (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_b),
        .mem_rdata(rd_b), .done(done_b), .result(res_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic put_node(input logic [7:0] at, input logic [7:0] link, input logic [7:0] val);
        mem[at]        = link;
        mem[8'(at + 1)] = val;
    endtask

    // Expected sum and node count from the chain rules alone.
    task automatic walk(output logic [15:0] s, output int n);
        logic [7:0] p;
        p = 8'h00;
        s = '0;
        n = 0;
        do begin
            s = s + {{8{mem[8'(p + 1)][7]}}, mem[8'(p + 1)]};
            n++;
            p = mem[p];
        end while (p != 8'h00 && n < 300);
    endtask

    // Driver: pushes the expected item, launches, optionally disturbs.
    task automatic run_chain(input bit disturb);
        logic [15:0] s;
        int n;
        walk(s, n);
        exp_sum_q.push_back(s);
        exp_lat_q.push_back(2 * n + 1); // captured edge plus 2N edges (R5)
        @(negedge clk);
        launch_cyc = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 head value address", {24'd0, addr_a}, 32'd1);
        check("R2 done cleared", {31'd0, done_a}, 32'd0);
        if (disturb) begin
            repeat (2) @(negedge clk);
            start = 1'b1; // R7 start during traversal
            @(negedge clk);
            start = 1'b0;
        end
        wait (exp_sum_q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: pops on each rising done and compares.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_a && !prev_done) begin
                if (exp_sum_q.size() == 0) begin
                    check("R7 unexpected completion", 32'd1, 32'd0);
                end else begin
                    logic [15:0] es;
                    int el;
                    es = exp_sum_q.pop_front();
                    el = exp_lat_q.pop_front();
                    check("R3 sum", {16'd0, res_a}, {16'd0, es});
                    check("R8 shared adder sum", {16'd0, res_b}, {16'd0, es});
                    check("R8 shared adder done", {31'd0, done_b}, 32'd1);
                    check("R5 latency", 32'(cyc - launch_cyc), 32'(el));
                end
            end
            prev_done <= done_a;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 done after reset", {31'd0, done_a}, 32'd0);
        check("R1 result after reset", {16'd0, res_a}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // single node
        put_node(8'h00, 8'h00, 8'h05);
        run_chain(1'b0);
        repeat (6) @(negedge clk);
        check("R6 done held", {31'd0, done_a}, 32'd1);
        check("R6 result held", {16'd0, res_a}, 32'h0005);

        // extreme signed bytes
        put_node(8'h00, 8'h40, 8'h7F);
        put_node(8'h40, 8'h10, 8'h80);
        put_node(8'h10, 8'h00, 8'hFF);
        run_chain(1'b0);
        check("R3 signed mix", {16'd0, res_a}, 32'h0000FFFE);

        // same chain, start pulsed mid-walk
        run_chain(1'b1);
        check("R7 result unchanged", {16'd0, res_a}, 32'h0000FFFE);

        // value address wraps 255 -> 0
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        put_node(8'h00, 8'hFF, 8'h03);
        mem[8'hFF] = 8'h00;
        run_chain(1'b0);
        check("R4 wrap sum", {16'd0, res_a}, 32'h0002);

        // long chain, restarted right after previous done
        for (int i = 0; i < 100; i++)
            put_node(8'(2 * i), (i == 99) ? 8'h00 : 8'(2 * i + 2), 8'h80);
        run_chain(1'b0);
        check("R3 long chain", {16'd0, res_a}, {16'd0, 16'(-12800)});

        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

endmodule